// File: doc/BRIEF.md
# Synchronous Burst Wait-Pin Monitor

This block paces the read beats of a synchronous external memory access. When an access is requested, it latches a set of timing values in clock cycles. These are the delay to the first beat, the spacing of later beats, the minimum length of the whole access, and the burst length. It then decides in which clock each beat's data is captured. The device can hold off a beat by driving its active-low wait input low. The block can be told to treat the wait level as valid in the same clock as the data, or one clock ahead of it.

While a beat is due but held off by wait, a cycle-length counter is frozen. It resumes once wait is seen released. After the last capture, the access stays busy until that counter reaches the programmed cycle time, and then signals completion for one clock. Chip-select, address and output-enable waveforms, address decoding and register access are outside this block.

Top module: `burst_wait_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `capture` and `done` are 0 and `beat_idx` is 0.
- R2: `start` is taken only when `busy` is 0. The next cycle `busy` is 1 and all configuration inputs are latched. A `start` or a configuration change while `busy` is 1 has no effect on the running access.
- R3: Number the busy cycles from 0. Beat 0 is captured no earlier than busy cycle `first_acc`, and in exactly that cycle when the device is ready.
- R4: Each later beat has its own access phase, which starts at cycle 0 in the clock after the previous capture. The beat is captured no earlier than phase cycle `burst_acc`. A value of 0 gives back-to-back captures.
- R5: With monitoring on and `wait_lead`=0, a due beat is captured only in a cycle where `wait_n` is 1; `wait_n`=0 means not ready.
- R6: With monitoring on and `wait_lead`=1, a due beat is captured only when `wait_n` was 1 in the previous clock.
- R7: With `wait_mon_en`=0, `wait_n` is ignored and every beat is captured in the first cycle it is due.
- R8: A cycle counter starts at 0 on acceptance. It counts every busy cycle, saturating at `cycle_time`, except cycles in which a due beat is held off by wait.
- R9: `beat_idx` is 0 for the first beat and rises by one after each capture except the last. The burst has `burst_len_m1`+1 beats (1 to 16).
- R10: `done` is a one-cycle pulse in the first cycle after the last capture in which the cycle counter is at least `cycle_time`. `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Access request |
| wait_mon_en | input | 1 | Enable wait monitoring |
| wait_lead | input | 1 | 0: wait valid with data; 1: wait valid one clock earlier |
| first_acc | input | CNT_W | First-beat access time in cycles |
| burst_acc | input | CNT_W | Later-beat access time in cycles |
| cycle_time | input | CNT_W | Minimum access length in cycles |
| burst_len_m1 | input | BEAT_W | Number of beats minus one |
| wait_n | input | 1 | Device wait, low = not ready |
| busy | output | 1 | Access in progress |
| capture | output | 1 | Capture the data bus this clock |
| beat_idx | output | BEAT_W | Index of the current beat |
| done | output | 1 | Access complete pulse |

## Verification
The hardest state to reach is a due beat held off by wait while the cycle counter has not yet reached its limit. Only there does the freeze of R8 change when `done` fires. The stimulus drives long access times together with cycle times longer than the whole burst, and holds `wait_n` low across due beats in both lead settings. This moves the completion pulse by exactly the number of stalled cycles. Random wait patterns over 16-beat bursts with zero beat spacing cover stalls on back-to-back captures. Stray requests issued mid-access check that nothing is disturbed.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_TAIL = 2'd2
  } bwm_state_e;
endpackage

// File: rtl/bwm_wait_sync.sv
// Turns the device wait level into a ready qualifier for the current clock.
module bwm_wait_sync #(
  parameter bit LEAD_SUPPORT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n,
  input  logic mon_en,
  input  logic lead,
  output logic ready
);
  logic lead_level;

  generate
    if (LEAD_SUPPORT) begin : g_lead
      logic wait_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_q <= 1'b1;
        else        wait_q <= wait_n;
      end
      assign lead_level = wait_q;
    end else begin : g_nolead
      assign lead_level = wait_n;
    end
  endgenerate

  always_comb begin
    if (!mon_en)   ready = 1'b1;
    else if (lead) ready = lead_level;
    else           ready = wait_n;
  end

  // R5: same-clock mode never reports ready while the device holds wait low
  always_comb begin
    if (rst_n && mon_en && !lead)
      assert_ready_same_clock_R5: assert (!ready || wait_n);
  end
endmodule

// File: rtl/bwm_access_timer.sv
// Counts cycles within one beat's access phase and flags when the beat is due.
module bwm_access_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] target,
  output logic             due
);
  logic [CNT_W-1:0] acnt_q, acnt_d;

  always_comb begin
    acnt_d = acnt_q;
    if (clear)                     acnt_d = '0;
    else if (run && acnt_q < target) acnt_d = acnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acnt_q <= '0;
    else        acnt_q <= acnt_d;
  end

  assign due = (acnt_q >= target);

  // R4: a cleared phase restarts from zero
  assert_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acnt_q == '0));
endmodule

// File: rtl/bwm_cycle_counter.sv
// Access-length counter: freezes while run is low, saturates at the limit.
module bwm_cycle_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             reached
);
  logic [CNT_W-1:0] ccnt_q, ccnt_d;

  always_comb begin
    ccnt_d = ccnt_q;
    if (clear)                      ccnt_d = '0;
    else if (run && ccnt_q < limit) ccnt_d = ccnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccnt_q <= '0;
    else        ccnt_q <= ccnt_d;
  end

  assign reached = (ccnt_q >= limit);

  // R8: frozen while held off
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(ccnt_q));
endmodule

// File: rtl/burst_wait_monitor.sv
module burst_wait_monitor #(
  parameter int CNT_W      = 6,
  parameter int MAX_BEATS  = 16,
  parameter bit LEAD_SUPPORT = 1'b1,
  localparam int BEAT_W    = $clog2(MAX_BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wait_mon_en,
  input  logic              wait_lead,
  input  logic [CNT_W-1:0]  first_acc,
  input  logic [CNT_W-1:0]  burst_acc,
  input  logic [CNT_W-1:0]  cycle_time,
  input  logic [BEAT_W-1:0] burst_len_m1,
  input  logic              wait_n,
  output logic              busy,
  output logic              capture,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              done
);
  import bwm_pkg::*;

  bwm_state_e state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0]  first_q, burst_q, cyc_q;
  logic [BEAT_W-1:0] len_q;
  logic              en_q, lead_q;

  logic accept, ready, due, last, stall, reached, cc_run;
  logic [CNT_W-1:0] target;

  assign accept = (state_q == ST_IDLE) && start;
  assign target = (beat_q == '0) ? first_q : burst_q;
  assign last   = (beat_q == len_q);

  bwm_wait_sync #(.LEAD_SUPPORT(LEAD_SUPPORT)) u_wait (
    .clk(clk), .rst_n(rst_n), .wait_n(wait_n),
    .mon_en(en_q), .lead(lead_q), .ready(ready)
  );

  bwm_access_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept || capture),
    .run(state_q == ST_BEAT), .target(target), .due(due)
  );

  assign capture = (state_q == ST_BEAT) && due && ready;
  assign stall   = (state_q == ST_BEAT) && due && !ready;
  assign cc_run  = ((state_q == ST_BEAT) && !stall) || (state_q == ST_TAIL);

  bwm_cycle_counter #(.CNT_W(CNT_W)) u_cycle (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .run(cc_run), .limit(cyc_q), .reached(reached)
  );

  assign done = (state_q == ST_TAIL) && reached;

  // next state
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_BEAT;
        beat_d  = '0;
      end
      ST_BEAT: if (capture) begin
        if (last) state_d = ST_TAIL;
        else      beat_d  = beat_q + 1'b1;
      end
      ST_TAIL: if (reached) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  // configuration latched on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      burst_q <= '0;
      cyc_q   <= '0;
      len_q   <= '0;
      en_q    <= 1'b0;
      lead_q  <= 1'b0;
    end else if (accept) begin
      first_q <= first_acc;
      burst_q <= burst_acc;
      cyc_q   <= cycle_time;
      len_q   <= burst_len_m1;
      en_q    <= wait_mon_en;
      lead_q  <= wait_lead;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign beat_idx = beat_q;

  assert_capture_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> busy);
  assert_lead_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && en_q && lead_q) |-> $past(wait_n));
  assert_beat_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (beat_idx <= len_q));
  assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(len_q)));
endmodule

// File: tb/tb_burst_wait_monitor.sv
module tb_burst_wait_monitor;
  localparam int CNT_W = 6;
  localparam int BEAT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wait_mon_en = 1'b0, wait_lead = 1'b0, wait_n = 1'b1;
  logic [CNT_W-1:0] first_acc = '0, burst_acc = '0, cycle_time = '0;
  logic [BEAT_W-1:0] burst_len_m1 = '0;
  logic busy, capture, done;
  logic [BEAT_W-1:0] beat_idx;

  always #4 clk = ~clk; // 125 MHz

  burst_wait_monitor dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_mon_en(wait_mon_en),
    .wait_lead(wait_lead), .first_acc(first_acc), .burst_acc(burst_acc),
    .cycle_time(cycle_time), .burst_len_m1(burst_len_m1), .wait_n(wait_n),
    .busy(busy), .capture(capture), .beat_idx(beat_idx), .done(done)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit reset_phase = 1'b1;

  // configuration requested by the stimulus, applied inside tick
  int c_first, c_burst, c_cyc, c_len, c_en, c_lead;

  // behavioural reference
  int m_state, m_acnt, m_ccnt, m_beat, m_wprev;
  int k_first, k_burst, k_cyc, k_len, k_en, k_lead;

  task automatic cmp(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic tick(input logic s, input logic w);
    int tgt, rdy, e_due, e_cap, e_done;
    @(negedge clk);
    cycles++;
    start = s; wait_n = w;
    first_acc = CNT_W'(c_first); burst_acc = CNT_W'(c_burst);
    cycle_time = CNT_W'(c_cyc); burst_len_m1 = BEAT_W'(c_len);
    wait_mon_en = c_en[0]; wait_lead = c_lead[0];
    #1;
    tgt = (m_beat == 0) ? k_first : k_burst;
    rdy = !k_en ? 1 : (k_lead ? m_wprev : int'(w));
    e_due = (m_acnt >= tgt);
    e_cap = (m_state == 1 && e_due && rdy) ? 1 : 0;
    e_done = (m_state == 2 && m_ccnt >= k_cyc) ? 1 : 0;
    cmp(reset_phase ? "R1" : "R2", int'(busy), (m_state != 0) ? 1 : 0);
    cmp(!k_en ? "R7" : (k_lead ? "R6" : (m_beat == 0 ? "R3" : "R5")), int'(capture), e_cap);
    cmp(reset_phase ? "R1" : "R9", int'(beat_idx), m_beat);
    // done timing also exposes the counter freeze of R8
    cmp(reset_phase ? "R1" : "R10", int'(done), e_done);
    reset_phase = 1'b0;
    // model the coming rising edge
    case (m_state)
      0: if (s) begin
        k_first = c_first; k_burst = c_burst; k_cyc = c_cyc;
        k_len = c_len; k_en = c_en; k_lead = c_lead;
        m_state = 1; m_acnt = 0; m_ccnt = 0; m_beat = 0;
      end
      1: begin
        if (!(e_due && !rdy) && m_ccnt < k_cyc) m_ccnt++;
        if (e_cap) begin
          if (m_beat == k_len) m_state = 2;
          else begin m_beat++; m_acnt = 0; end
        end else if (m_acnt < tgt) m_acnt++;
      end
      default: begin
        if (e_done) m_state = 0;
        else if (m_ccnt < k_cyc) m_ccnt++;
      end
    endcase
    m_wprev = int'(w);
  endtask

  // wmode: 0 always ready, 1 random, 2 low in the window [lo,hi) of busy cycles
  task automatic run_access(input int fa, input int ba, input int cy, input int ln,
                            input int en, input int ld, input int wmode,
                            input int lo, input int hi, input bit stray);
    int n;
    c_first = fa; c_burst = ba; c_cyc = cy; c_len = ln; c_en = en; c_lead = ld;
    tick(1'b1, 1'b1);
    // scramble requested config: latched copy must stay in force (R2)
    c_first = 1; c_burst = 0; c_cyc = 0; c_len = 0; c_en = 0; c_lead = 0;
    n = 0;
    while (m_state != 0 && n < 3000) begin
      logic w;
      case (wmode)
        0: w = 1'b1;
        1: w = ($urandom % 3) != 0;
        default: w = !(n >= lo && n < hi);
      endcase
      tick(stray && (n % 5 == 2), w);
      n++;
    end
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
  endtask

  initial begin
    m_state = 0; m_acnt = 0; m_ccnt = 0; m_beat = 0; m_wprev = 1;
    k_first = 0; k_burst = 0; k_cyc = 0; k_len = 0; k_en = 0; k_lead = 0;
    c_first = 0; c_burst = 0; c_cyc = 0; c_len = 0; c_en = 0; c_lead = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (busy !== 1'b0 || capture !== 1'b0 || done !== 1'b0 || beat_idx !== '0) begin
      miscompares++;
      $display("FAIL R1: actual %b%b%b/%0d expected 000/0 in reset", busy, capture, done, beat_idx);
    end
    rst_n = 1'b1;
    tick(1'b0, 1'b1);                         // R1 first cycle after reset
    run_access(3, 0, 2, 0, 0, 0, 0, 0, 0, 0);   // R3 single beat, no monitoring
    run_access(0, 0, 0, 3, 0, 0, 1, 0, 0, 0);   // R7 wait toggles, ignored
    run_access(2, 1, 30, 3, 1, 0, 2, 2, 6, 0);  // R5/R8 stall delays done
    run_access(2, 1, 30, 3, 1, 1, 2, 2, 6, 0);  // R6 lead one clock
    run_access(1, 0, 4, 15, 1, 0, 1, 0, 0, 1);  // R9 16 beats, stray start R2
    run_access(4, 2, 50, 7, 1, 1, 1, 0, 0, 1);  // R6 random, long cycle R10
    for (int i = 0; i < 40; i++)
      run_access($urandom % 6, $urandom % 4, $urandom % 40, $urandom % 16,
                 $urandom % 2, $urandom % 2, 1, 0, 0, i[0]);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1400000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule